// File: doc/BRIEF.md
# Short Packet Capture Queue

This block sits behind the packet decoder of a camera serial receiver. Every short packet (frame start/end, line start/end, generic codes) that the decoder hands over is packed into one 24-bit word and kept in a small first-in first-out store of 31 entries. Software drains the store through a single read-only data register: each read returns the oldest entry and removes it as a side effect. An empty queue reads as zero and is left alone.

Two level flags (full, holding data) feed a status register. Two single-cycle event strobes feed the interrupt collector. The first strobe reports that data is waiting. It fires again after each read that leaves entries behind, so a read-and-clear loop in software keeps being re-triggered until the queue is dry. The second strobe reports that a packet was lost because the queue was full. A lost packet never disturbs the entries already held.

Top module: `spkt_capture_fifo`

## Requirements
- R1: The read word carries the packet data in bits 23:8, the virtual channel in bits 7:6 and the data type in bits 5:0; bits 31:24 are zero.
- R2: Entries leave the queue in the order they arrived, and up to DEPTH (default 31) entries are held.
- R3: `sts_full` is 1 exactly when DEPTH entries are held; `sts_nonempty` is 1 exactly when at least one entry is held. Both follow the clock edge that changes the fill level.
- R4: A cycle with `rd_pop` high while entries are held removes exactly one entry (the one shown on `rd_word` in that cycle).
- R5: While the queue is empty, `rd_word` reads 0, and `rd_pop` changes nothing.
- R6: A packet offered while the queue is full and no entry is removed in the same cycle is dropped, the held entries stay intact, and `evt_overflow` is high for exactly the following cycle.
- R7: A packet offered in the same cycle as a removal is stored even when the queue is full, and the fill level is unchanged.
- R8: `evt_nonempty` is high for one cycle after a clock edge that stores a packet into an empty queue, and for one cycle after each removal that leaves entries behind.
- R9: After reset the queue is empty, both flags and both strobes are 0, and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | A decoded short packet is offered this cycle |
| pkt_data | input | 16 | Packet data field |
| pkt_vc | input | 2 | Virtual channel of the packet |
| pkt_dtype | input | 6 | Data type code of the packet |
| rd_pop | input | 1 | Software read of the data register this cycle |
| rd_word | output | 32 | Oldest entry, packed; 0 when empty |
| sts_full | output | 1 | Queue holds DEPTH entries |
| sts_nonempty | output | 1 | Queue holds at least one entry |
| evt_nonempty | output | 1 | One-cycle event: data waiting |
| evt_overflow | output | 1 | One-cycle event: a packet was dropped |

## Verification
`rd_word` is a function of the stored state only, so it is due in the same cycle the state exists and is compared before new inputs are driven. The flags and both event strobes are due one clock edge after the stimulus that caused them. The bench therefore drives inputs just after a falling edge, advances its queue model at the rising edge, and compares all five outputs at the next falling edge. Drain order and the single overflow pulse of a 32-packet burst are also checked with explicit expected values.

// File: rtl/spkt_pkg.sv
package spkt_pkg;
   localparam int DATA_W = 16;
   localparam int VC_W   = 2;
   localparam int DT_W   = 6;
   localparam int ENTRY_W = DATA_W + VC_W + DT_W;

   // Field order sets the bit positions of the packed word (R1)
   typedef struct packed {
      logic [DATA_W-1:0] data;
      logic [VC_W-1:0]   vc;
      logic [DT_W-1:0]   dtype;
   } spkt_entry_t;
endpackage

// File: rtl/spkt_store.sv
module spkt_store
   import spkt_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int AW    = 5
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  spkt_entry_t   wr_entry,
   input  logic [AW-1:0] rd_addr,
   output spkt_entry_t   rd_entry
);
   spkt_entry_t slots [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) slots[wr_addr] <= wr_entry;
   end

   assign rd_entry = slots[rd_addr];
endmodule

// File: rtl/spkt_ptrs.sv
module spkt_ptrs #(
   parameter int DEPTH = 31,
   parameter int AW    = 5,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] level,
   output logic [CW-1:0] level_next,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          drop
);
   localparam logic [CW-1:0] LVL_MAX = CW'(DEPTH);

   logic [AW-1:0] wr_inc, rd_inc;
   logic          at_max, at_zero;

   assign at_max  = (level == LVL_MAX);
   assign at_zero = (level == '0);
   assign pop_ok  = pop_req & ~at_zero;
   assign push_ok = push_req & (~at_max | pop_ok);
   assign drop    = push_req & at_max & ~pop_ok;

   generate
      if ((1 << AW) == DEPTH) begin : g_wrap_natural
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_comb begin
      level_next = level;
      if (push_ok && !pop_ok) level_next = level + 1'b1;
      else if (pop_ok && !push_ok) level_next = level - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_inc;
         if (pop_ok)  rd_ptr <= rd_inc;
         level <= level_next;
      end
   end
endmodule

// File: rtl/spkt_events.sv
module spkt_events #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] level_next,
   input  logic          pop_ok,
   input  logic          drop,
   output logic          evt_nonempty,
   output logic          evt_overflow
);
   logic ne_set;

   // Fires when data appears in an empty queue, or a removal leaves data behind
   assign ne_set = (level_next != '0) && ((level == '0) || pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_nonempty <= 1'b0;
         evt_overflow <= 1'b0;
      end else begin
         evt_nonempty <= ne_set;
         evt_overflow <= drop;
      end
   end
endmodule

// File: rtl/spkt_capture_fifo.sv
module spkt_capture_fifo
   import spkt_pkg::*;
#(
   parameter int DEPTH  = 31,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [DATA_W-1:0] pkt_data,
   input  logic [VC_W-1:0]   pkt_vc,
   input  logic [DT_W-1:0]   pkt_dtype,
   input  logic              rd_pop,
   output logic [WORD_W-1:0] rd_word,
   output logic              sts_full,
   output logic              sts_nonempty,
   output logic              evt_nonempty,
   output logic              evt_overflow
);
   localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
         $error("spkt_capture_fifo: DEPTH must lie in 2..1024");
      end
      if (WORD_W < ENTRY_W) begin : g_bad_word
         $error("spkt_capture_fifo: WORD_W narrower than a packed entry");
      end
   endgenerate

   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] level, level_next;
   logic          push_ok, pop_ok, drop;
   spkt_entry_t   in_entry, head_entry;

   assign in_entry.data  = pkt_data;
   assign in_entry.vc    = pkt_vc;
   assign in_entry.dtype = pkt_dtype;

   spkt_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_req   (pkt_valid),
      .pop_req    (rd_pop),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .level      (level),
      .level_next (level_next),
      .push_ok    (push_ok),
      .pop_ok     (pop_ok),
      .drop       (drop)
   );

   spkt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk      (clk),
      .wr_en    (push_ok),
      .wr_addr  (wr_ptr),
      .wr_entry (in_entry),
      .rd_addr  (rd_ptr),
      .rd_entry (head_entry)
   );

   spkt_events #(.CW(CW)) u_events (
      .clk          (clk),
      .rst_n        (rst_n),
      .level        (level),
      .level_next   (level_next),
      .pop_ok       (pop_ok),
      .drop         (drop),
      .evt_nonempty (evt_nonempty),
      .evt_overflow (evt_overflow)
   );

   assign sts_full     = (level == CW'(DEPTH));
   assign sts_nonempty = (level != '0);

   generate
      if (WORD_W > ENTRY_W) begin : g_pad
         assign rd_word = sts_nonempty ? {{(WORD_W-ENTRY_W){1'b0}}, head_entry} : '0;
      end else begin : g_nopad
         assign rd_word = sts_nonempty ? head_entry : '0;
      end
   endgenerate
endmodule

// File: rtl/spkt_capture_fifo_chk.sv
module spkt_capture_fifo_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_valid,
   input logic              rd_pop,
   input logic [WORD_W-1:0] rd_word,
   input logic              sts_full,
   input logic              sts_nonempty,
   input logic              evt_nonempty,
   input logic              evt_overflow
);
   p_full_implies_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sts_full |-> sts_nonempty);

   p_empty_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_nonempty |-> (rd_word == '0));

   p_empty_pop_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_nonempty && rd_pop && !pkt_valid) |=> !sts_nonempty);

   p_pop_leaves_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_full && rd_pop && !pkt_valid) |=> !sts_full);

   p_drop_keeps_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_full && pkt_valid && !rd_pop) |=> (sts_full && evt_overflow));

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts_full || !pkt_valid || rd_pop) |=> !evt_overflow);

   p_swap_at_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_full && pkt_valid && rd_pop) |=> sts_full);

   p_event_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_nonempty |-> sts_nonempty);
endmodule

bind spkt_capture_fifo spkt_capture_fifo_chk #(.WORD_W(WORD_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pkt_valid    (pkt_valid),
   .rd_pop       (rd_pop),
   .rd_word      (rd_word),
   .sts_full     (sts_full),
   .sts_nonempty (sts_nonempty),
   .evt_nonempty (evt_nonempty),
   .evt_overflow (evt_overflow)
);

// File: tb/spkt_capture_fifo_test.sv
module spkt_capture_fifo_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [15:0] pkt_data = '0;
   logic [1:0]  pkt_vc = '0;
   logic [5:0]  pkt_dtype = '0;
   logic        rd_pop = 1'b0;
   logic [31:0] rd_word;
   logic        sts_full, sts_nonempty, evt_nonempty, evt_overflow;

   int vectors = 0;
   int miscompares = 0;
   int ovf_seen = 0;
   int cycles = 0;

   logic [23:0] model_q [$];
   bit exp_ne_evt = 0;
   bit exp_ovf_evt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spkt_capture_fifo uut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_vc(pkt_vc), .pkt_dtype(pkt_dtype), .rd_pop(rd_pop), .rd_word(rd_word),
      .sts_full(sts_full), .sts_nonempty(sts_nonempty),
      .evt_nonempty(evt_nonempty), .evt_overflow(evt_overflow)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   // Compare every output against the model state of this cycle
   task automatic compare_all();
      logic [31:0] exp_word;
      exp_word = (model_q.size() != 0) ? {8'h00, model_q[0]} : 32'h0;
      chk("R1/R2 rd_word", rd_word, exp_word);
      chk("R3 sts_full", {31'h0, sts_full}, {31'h0, model_q.size() == DEPTH});
      chk("R3 sts_nonempty", {31'h0, sts_nonempty}, {31'h0, model_q.size() != 0});
      chk("R8 evt_nonempty", {31'h0, evt_nonempty}, {31'h0, exp_ne_evt});
      chk("R6 evt_overflow", {31'h0, evt_overflow}, {31'h0, exp_ovf_evt});
      if (evt_overflow) ovf_seen++;
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic cyc(input bit v, input logic [15:0] d, input logic [1:0] c,
                      input logic [5:0] t, input bit p);
      bit was_empty, pop_ok, push_ok, drop;
      compare_all();
      pkt_valid = v; pkt_data = d; pkt_vc = c; pkt_dtype = t; rd_pop = p;
      was_empty = (model_q.size() == 0);
      pop_ok  = p && !was_empty;
      push_ok = v && ((model_q.size() != DEPTH) || pop_ok);
      drop    = v && (model_q.size() == DEPTH) && !pop_ok;
      @(posedge clk);
      if (pop_ok) void'(model_q.pop_front());
      if (push_ok) model_q.push_back({d, c, t});
      exp_ovf_evt = drop;
      exp_ne_evt  = (model_q.size() != 0) && (was_empty || pop_ok);
      @(negedge clk);
      pkt_valid = 1'b0; rd_pop = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      chk("R9 rd_word", rd_word, 32'h0);
      chk("R9 flags", {30'h0, sts_full, sts_nonempty}, 32'h0);
      chk("R9 events", {30'h0, evt_nonempty, evt_overflow}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: reads of an empty queue
      cyc(0, 16'h0, 2'd0, 6'd0, 1);
      cyc(0, 16'h0, 2'd0, 6'd0, 1);
      chk("R5 empty read", rd_word, 32'h0);

      // R1: packing of one packet
      cyc(1, 16'hA5A5, 2'd3, 6'h2A, 0);
      chk("R1 packed word", rd_word, 32'h00A5A5EA);
      cyc(0, 16'h0, 2'd0, 6'd0, 1);   // R4: pop it
      chk("R4 popped to empty", {31'h0, sts_nonempty}, 32'h0);

      // R2/R6: 32 packets into an empty queue, last one dropped
      ovf_seen = 0;
      for (int i = 0; i < 32; i++)
         cyc(1, 16'(i), 2'(i), 6'(i + 8), 0);
      cyc(0, 16'h0, 2'd0, 6'd0, 0);
      chk("R6 single overflow pulse", 32'(ovf_seen), 32'd1);
      chk("R3 full after 31", {31'h0, sts_full}, 32'h1);
      chk("R6 head intact", rd_word, {8'h00, 16'h0000, 2'd0, 6'd8});

      // R7: push and pop together while full
      cyc(1, 16'h0100, 2'd1, 6'h12, 1);
      cyc(0, 16'h0, 2'd0, 6'd0, 0);
      chk("R7 still full", {31'h0, sts_full}, 32'h1);

      // R2: drain in order
      for (int k = 0; k < 31; k++) begin
         chk("R2 drain order", {16'h0, rd_word[23:8]},
             {16'h0, (k < 30) ? 16'(k + 1) : 16'h0100});
         cyc(0, 16'h0, 2'd0, 6'd0, 1);
      end
      cyc(0, 16'h0, 2'd0, 6'd0, 1);   // R5: extra read after drain
      chk("R5 drained", rd_word, 32'h0);

      // R8 and mixed traffic
      lfsr = 32'h1D872B41;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         cyc(lfsr[3] | lfsr[9], lfsr[27:12], lfsr[5:4], lfsr[11:6], lfsr[2] & lfsr[7]);
      end
      compare_all();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule